// File: doc/BRIEF.md
# Parallel Flash Software-ID Probe Sequencer

This block interrogates a byte-wide parallel flash device for its identity codes without any help from software. After a start pulse it can wait out a settling delay, puts the device into a known state with a reset command, sends the three-write unlock that switches the device into identification mode, and reads the manufacturer and device bytes. Either byte may be the continuation value 0x7F. In that case one more byte is read, and the code is extended to 16 bits.

The sequencer then leaves identification mode with the same command used for the reset. It reads the same locations again to see whether the codes it captured were only ordinary array contents. It compares the extended codes with the expected values on its inputs and checks odd parity on the final manufacturer byte. All device traffic goes through a simple request/acknowledge byte port. The unlock addresses on that port are reduced by one of three selectable masks, which suits devices that decode only part of the address. Delays are counted in clock cycles. A zero-timing mode removes every delay.

Top module: `flash_id_probe`

## Requirements
- R1: The unlock addresses are 0x5555 and 0x2AAA ANDed with a mask chosen by `mask_sel_i`: 0 selects 0xFFFF, 1 selects 0x07FF, 2 selects 0x0FFF, 3 selects 0xFFFF. Reads of the ID locations are never masked.
- R2: The reset before ID entry is a write of 0xF0 to the first unlock address. With `long_reset_i` set, a write of 0xAA to the first unlock address and a write of 0x55 to the second unlock address come first.
- R3: ID entry is three writes in order: 0xAA to the first unlock address, 0x55 to the second, and 0x90 to the first.
- R4: Between consecutive writes inside one command there are exactly GAP_CYC idle request cycles. After the 0x90 write there are at least ENTER_CYC idle cycles, and after each 0xF0 write at least EXIT_CYC. Between start and the first request there are at least ENTER_CYC idle cycles. With `zero_timing_i` set, all these counts are 0.
- R5: In ID mode the block reads offset 0 and then offset 1. If the offset-0 byte is 0x7F it then reads offset 0x100. After that, if the offset-1 byte is 0x7F, it reads offset 0x101. A code is {0x7F, continuation byte} when continued and {0x00, byte} otherwise. The codes appear on `mfr_id_o` and `dev_id_o`.
- R6: After the ID reads the block sends an exit command identical to the reset of R2. It then reads the same offsets again under the same continuation rule.
- R7: `mfr_is_array_o` / `dev_is_array_o` are 1 when the code read after exit equals the code read in ID mode.
- R8: `parity_err_o` is 1 when bits [7:0] of the manufacturer code have an even number of ones.
- R9: `match_o` is 1 only when the manufacturer code equals `exp_mfr_i` and the device code equals `exp_dev_i`, with both values sampled at start.
- R10: `busy_o` rises in the cycle after start is accepted and stays high until the run ends. `done_o` pulses once per run with `busy_o` low. A start pulse while busy is ignored.
- R11: A request holds `bus_req_o`, address, data and `bus_we_o` steady until `bus_ack_i`. Exactly one transfer completes per cycle with both high. Reads drive `bus_we_o` low.
- R12: After reset the block is idle: no request, `busy_o`, `done_o`, `match_o` low, ID outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a probe run (ignored while busy) |
| mask_sel_i | input | 2 | Unlock address mask select |
| long_reset_i | input | 1 | Prefix reset/exit with the two unlock writes |
| zero_timing_i | input | 1 | Remove all delays |
| exp_mfr_i | input | 16 | Expected manufacturer code |
| exp_dev_i | input | 16 | Expected device code |
| bus_req_o | output | 1 | Byte transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| match_o | output | 1 | Both codes equal the expected values |
| parity_err_o | output | 1 | Manufacturer byte fails odd parity |
| mfr_id_o | output | 16 | Extended manufacturer code |
| dev_id_o | output | 16 | Extended device code |
| mfr_is_array_o | output | 1 | Manufacturer code also read in array mode |
| dev_is_array_o | output | 1 | Device code also read in array mode |

## Verification
The bench builds the block with GAP_CYC=3, ENTER_CYC=20 and EXIT_CYC=7. With these short delays every idle window can be counted exactly or bounded within a few hundred cycles per run. This allows a full sweep over all four mask selections, both reset lengths, both timing modes and six ID patterns. The patterns cover plain codes, continuation on either code or both, a parity failure, and array contents that mimic the ID. A small device model enters ID mode only when it sees the unlock writes at the masked addresses, so a wrong mask or command order shows up in the codes returned. The bench also varies acknowledge latency from 0 to 2 cycles.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  localparam logic [15:0] UNLOCK_A     = 16'h5555;
  localparam logic [15:0] UNLOCK_B     = 16'h2AAA;
  localparam logic [7:0]  CMD_KEY_A    = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_ID_ENTER = 8'h90;
  localparam logic [7:0]  CMD_RESET    = 8'hF0;
  localparam logic [7:0]  CONT_CODE    = 8'h7F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_RST, ST_ENT, ST_RDID, ST_EXIT, ST_RDARR
  } probe_st_e;

  function automatic logic [15:0] unlock_mask(input logic [1:0] sel);
    case (sel)
      2'd1:    return 16'h07FF;
      2'd2:    return 16'h0FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] extend_code(input logic [7:0] first,
                                              input logic [7:0] second);
    return (first == CONT_CODE) ? {CONT_CODE, second} : {8'h00, first};
  endfunction

endpackage

// File: rtl/flash_id_timer.sv
module flash_id_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/flash_id_cmd.sv
module flash_id_cmd
  import flash_id_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              prefix_i,
  input  logic [7:0]        final_data_i,
  input  logic [CNT_W-1:0]  final_dly_i,
  input  logic [CNT_W-1:0]  gap_dly_i,
  input  logic [15:0]       mask_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              done_o
);

  typedef enum logic [1:0] {C_IDLE, C_WR, C_WAIT} cmd_st_e;

  cmd_st_e          st_q;
  logic [1:0]       step_q;
  logic             done_q;
  logic             last_step;
  logic [CNT_W-1:0] dly;
  logic             tmr_load;
  logic             tmr_zero;
  logic [15:0]      base_addr;

  assign last_step = (step_q == 2'd2);
  assign dly       = last_step ? final_dly_i : gap_dly_i;
  assign tmr_load  = (st_q == C_WR) && ack_i && (dly != '0);

  flash_id_timer #(.CNT_W(CNT_W)) u_gap_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (dly - CNT_W'(1)),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        C_IDLE: if (go_i) begin
          step_q <= prefix_i ? 2'd0 : 2'd2;
          st_q   <= C_WR;
        end
        C_WR: if (ack_i) begin
          if (dly != '0) begin
            st_q <= C_WAIT;
          end else if (last_step) begin
            done_q <= 1'b1;
            st_q   <= C_IDLE;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        C_WAIT: if (tmr_zero) begin
          if (last_step) begin
            done_q <= 1'b1;
            st_q   <= C_IDLE;
          end else begin
            step_q <= step_q + 2'd1;
            st_q   <= C_WR;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    case (step_q)
      2'd1:    base_addr = UNLOCK_B;
      default: base_addr = UNLOCK_A;
    endcase
    case (step_q)
      2'd0:    wdata_o = CMD_KEY_A;
      2'd1:    wdata_o = CMD_KEY_B;
      default: wdata_o = final_data_i;
    endcase
  end

  assign addr_o = ADDR_W'(base_addr & mask_i);
  assign req_o  = (st_q == C_WR);
  assign done_o = done_q;

  // write held until accepted
  p_hold_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(wdata_o));

  p_step_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> step_q != 2'd3);

  // idle window of R4: no request while the gap timer runs
  p_gap_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_zero |-> !req_o);

endmodule

// File: rtl/flash_id_reader.sv
module flash_id_reader
  import flash_id_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              ack_i,
  input  logic [7:0]        rdata_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic [15:0]       code0_o,
  output logic [15:0]       code1_o
);

  logic       act_q;
  logic [1:0] idx_q;
  logic [7:0] b0_q, b1_q, c0_q, c1_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
      c0_q   <= '0;
      c1_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (go_i) begin
          act_q <= 1'b1;
          idx_q <= 2'd0;
          c0_q  <= '0;
          c1_q  <= '0;
        end
      end else if (ack_i) begin
        case (idx_q)
          2'd0: begin
            b0_q  <= rdata_i;
            idx_q <= 2'd1;
          end
          2'd1: begin
            b1_q <= rdata_i;
            if (b0_q == CONT_CODE)         idx_q <= 2'd2;
            else if (rdata_i == CONT_CODE) idx_q <= 2'd3;
            else begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
          2'd2: begin
            c0_q <= rdata_i;
            if (b1_q == CONT_CODE) idx_q <= 2'd3;
            else begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
          default: begin
            c1_q   <= rdata_i;
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  // bit 8 selects the continuation page, bit 0 the code
  assign addr_o  = ADDR_W'({idx_q[1], 7'b0, idx_q[0]});
  assign req_o   = act_q;
  assign done_o  = done_q;
  assign code0_o = extend_code(b0_q, c0_q);
  assign code1_o = extend_code(b1_q, c1_q);

  p_cont0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && idx_q == 2'd2 |-> b0_q == CONT_CODE);

  p_cont1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && idx_q == 2'd3 |-> b1_q == CONT_CODE);

  p_hold_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o));

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GAP_CYC   = 1000,
  parameter int ENTER_CYC = 1000000,
  parameter int EXIT_CYC  = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mask_sel_i,
  input  logic              long_reset_i,
  input  logic              zero_timing_i,
  input  logic [15:0]       exp_mfr_i,
  input  logic [15:0]       exp_dev_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [7:0]        bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              match_o,
  output logic              parity_err_o,
  output logic [15:0]       mfr_id_o,
  output logic [15:0]       dev_id_o,
  output logic              mfr_is_array_o,
  output logic              dev_is_array_o
);

  localparam int MAX_A   = (GAP_CYC > EXIT_CYC) ? GAP_CYC : EXIT_CYC;
  localparam int MAX_DLY = (ENTER_CYC > MAX_A) ? ENTER_CYC : MAX_A;
  localparam int CNT_W   = $clog2(MAX_DLY + 2);

  probe_st_e   st_q;
  logic [15:0] mask_q, exp_mfr_q, exp_dev_q;
  logic        long_q, zero_q;
  logic        cmd_go_q, rd_go_q, done_q;
  logic        match_q, par_q, mfr_arr_q, dev_arr_q;
  logic [15:0] mfr_q, dev_q;

  logic [CNT_W-1:0] gap_d, enter_d, exit_d;
  logic             pre_load, pre_zero;
  logic             cmd_prefix, cmd_req, cmd_done;
  logic [7:0]       cmd_final, cmd_wdata;
  logic [CNT_W-1:0] cmd_fdly;
  logic [ADDR_W-1:0] cmd_addr, rd_addr;
  logic             rd_req, rd_done;
  logic [15:0]      rd_code0, rd_code1;
  logic             enter_now;

  assign gap_d   = zero_q ? '0 : CNT_W'(GAP_CYC);
  assign enter_d = zero_q ? '0 : CNT_W'(ENTER_CYC);
  assign exit_d  = zero_q ? '0 : CNT_W'(EXIT_CYC);

  // pre-wait before reset uses the start-time timing mode
  assign enter_now = !zero_timing_i && (ENTER_CYC != 0);
  assign pre_load  = (st_q == ST_IDLE) && start_i && enter_now;

  flash_id_timer #(.CNT_W(CNT_W)) u_pre_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pre_load),
    .val_i  (CNT_W'(ENTER_CYC) - CNT_W'(1)),
    .zero_o (pre_zero)
  );

  assign cmd_prefix = (st_q == ST_ENT) || long_q;
  assign cmd_final  = (st_q == ST_ENT) ? CMD_ID_ENTER : CMD_RESET;
  assign cmd_fdly   = (st_q == ST_ENT) ? enter_d : exit_d;

  flash_id_cmd #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (cmd_go_q),
    .prefix_i     (cmd_prefix),
    .final_data_i (cmd_final),
    .final_dly_i  (cmd_fdly),
    .gap_dly_i    (gap_d),
    .mask_i       (mask_q),
    .ack_i        (bus_ack_i),
    .req_o        (cmd_req),
    .addr_o       (cmd_addr),
    .wdata_o      (cmd_wdata),
    .done_o       (cmd_done)
  );

  flash_id_reader #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (rd_go_q),
    .ack_i   (bus_ack_i),
    .rdata_i (bus_rdata_i),
    .req_o   (rd_req),
    .addr_o  (rd_addr),
    .done_o  (rd_done),
    .code0_o (rd_code0),
    .code1_o (rd_code1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      mask_q    <= 16'hFFFF;
      long_q    <= 1'b0;
      zero_q    <= 1'b0;
      exp_mfr_q <= '0;
      exp_dev_q <= '0;
      cmd_go_q  <= 1'b0;
      rd_go_q   <= 1'b0;
      done_q    <= 1'b0;
      match_q   <= 1'b0;
      par_q     <= 1'b0;
      mfr_arr_q <= 1'b0;
      dev_arr_q <= 1'b0;
      mfr_q     <= '0;
      dev_q     <= '0;
    end else begin
      cmd_go_q <= 1'b0;
      rd_go_q  <= 1'b0;
      done_q   <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q    <= unlock_mask(mask_sel_i);
          long_q    <= long_reset_i;
          zero_q    <= zero_timing_i;
          exp_mfr_q <= exp_mfr_i;
          exp_dev_q <= exp_dev_i;
          match_q   <= 1'b0;
          par_q     <= 1'b0;
          mfr_arr_q <= 1'b0;
          dev_arr_q <= 1'b0;
          mfr_q     <= '0;
          dev_q     <= '0;
          if (enter_now) st_q <= ST_PRE;
          else begin
            st_q     <= ST_RST;
            cmd_go_q <= 1'b1;
          end
        end
        ST_PRE: if (pre_zero) begin
          st_q     <= ST_RST;
          cmd_go_q <= 1'b1;
        end
        ST_RST: if (cmd_done) begin
          st_q     <= ST_ENT;
          cmd_go_q <= 1'b1;
        end
        ST_ENT: if (cmd_done) begin
          st_q    <= ST_RDID;
          rd_go_q <= 1'b1;
        end
        ST_RDID: if (rd_done) begin
          mfr_q    <= rd_code0;
          dev_q    <= rd_code1;
          st_q     <= ST_EXIT;
          cmd_go_q <= 1'b1;
        end
        ST_EXIT: if (cmd_done) begin
          st_q    <= ST_RDARR;
          rd_go_q <= 1'b1;
        end
        ST_RDARR: if (rd_done) begin
          mfr_arr_q <= (rd_code0 == mfr_q);
          dev_arr_q <= (rd_code1 == dev_q);
          match_q   <= (mfr_q == exp_mfr_q) && (dev_q == exp_dev_q);
          par_q     <= ~^mfr_q[7:0];
          done_q    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o      = cmd_req | rd_req;
  assign bus_we_o       = cmd_req;
  assign bus_addr_o     = rd_req ? rd_addr : cmd_addr;
  assign bus_wdata_o    = cmd_wdata;
  assign busy_o         = (st_q != ST_IDLE);
  assign done_o         = done_q;
  assign match_o        = match_q;
  assign parity_err_o   = par_q;
  assign mfr_id_o       = mfr_q;
  assign dev_id_o       = dev_q;
  assign mfr_is_array_o = mfr_arr_q;
  assign dev_is_array_o = dev_arr_q;

  p_one_master_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_req && rd_req));

  p_req_in_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_stay_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && st_q != ST_RDARR |=> busy_o);

  p_no_pre_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PRE |-> !bus_req_o);

endmodule

// File: tb/flash_id_probe_tb.sv
module flash_id_probe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int GAP   = 3;
  localparam int ENTER = 20;
  localparam int EXIT  = 7;
  localparam int K_NONE = 0, K_EXACT = 1, K_MIN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          start, long_rst, zero_t;
  logic [1:0]    msel;
  logic [15:0]   exp_mfr, exp_dev;
  logic          bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          busy, done, match, par_err, mfr_arr, dev_arr;
  logic [15:0]   mfr_id, dev_id;

  flash_id_probe #(.ADDR_W(AW), .GAP_CYC(GAP), .ENTER_CYC(ENTER), .EXIT_CYC(EXIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mask_sel_i(msel),
    .long_reset_i(long_rst), .zero_timing_i(zero_t),
    .exp_mfr_i(exp_mfr), .exp_dev_i(exp_dev),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .busy_o(busy), .done_o(done), .match_o(match), .parity_err_o(par_err),
    .mfr_id_o(mfr_id), .dev_id_o(dev_id),
    .mfr_is_array_o(mfr_arr), .dev_is_array_o(dev_arr)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // device model
  bit          idmode;
  int          ulk;
  logic [7:0]  idb [4];
  logic [7:0]  arb [4];
  logic [15:0] mdl_mask;

  function automatic logic [15:0] mask_of(input int s);
    case (s)
      1:       return 16'h07FF;
      2:       return 16'h0FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    int k;
    case (a)
      16'h0000: k = 0;
      16'h0001: k = 1;
      16'h0100: k = 2;
      16'h0101: k = 3;
      default:  return 8'hFF;
    endcase
    return idmode ? idb[k] : arb[k];
  endfunction

  function automatic logic [15:0] ext(input logic [7:0] b, input logic [7:0] c);
    return (b == 8'h7F) ? {8'h7F, c} : {8'h00, b};
  endfunction

  // recorded transfers
  logic        tr_we   [64];
  logic [15:0] tr_addr [64];
  logic [7:0]  tr_data [64];
  int          tr_gap  [64];
  int          ntr, low_cnt, lat_cnt, done_cnt, hold_err, run_idx;
  bit          holding;
  logic [15:0] hold_addr;

  // expected transfers
  logic        ex_we   [64];
  logic [15:0] ex_addr [64];
  logic [7:0]  ex_data [64];
  int          ex_kind [64];
  int          ex_gap  [64];
  string       ex_tag  [64];
  int          nex;

  int  cyc = 0;
  bit  finished = 0;

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual 0x%0h expected 0x%0h", cyc, 150000);
      finish_run();
    end
  end

  // bus responder and model, all at negedge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      bus_rdata = 8'h00;
    end else begin
      if (done) done_cnt++;
      if (!bus_req) low_cnt++;
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (holding && bus_addr != hold_addr) hold_err++;
        if (!holding) begin
          holding = 1;
          hold_addr = bus_addr;
        end
        if (lat_cnt >= (run_idx + ntr) % 3) begin
          if (ntr < 64) begin
            tr_we[ntr]   = bus_we;
            tr_addr[ntr] = bus_addr;
            tr_data[ntr] = bus_we ? bus_wdata : 8'h00;
            tr_gap[ntr]  = low_cnt;
          end
          ntr++;
          low_cnt = 0;
          if (bus_we) begin
            if (bus_wdata == 8'hF0 && bus_addr == (16'h5555 & mdl_mask)) begin
              idmode = 0; ulk = 0;
            end else if (ulk == 0 && bus_wdata == 8'hAA && bus_addr == (16'h5555 & mdl_mask)) ulk = 1;
            else if (ulk == 1 && bus_wdata == 8'h55 && bus_addr == (16'h2AAA & mdl_mask)) ulk = 2;
            else if (ulk == 2 && bus_wdata == 8'h90 && bus_addr == (16'h5555 & mdl_mask)) begin
              idmode = 1; ulk = 0;
            end else ulk = (bus_wdata == 8'hAA && bus_addr == (16'h5555 & mdl_mask)) ? 1 : 0;
          end else begin
            bus_rdata = mem_rd(bus_addr);
          end
          bus_ack = 1'b1;
          holding = 0;
          lat_cnt = 0;
        end else lat_cnt++;
      end
    end
  end

  task automatic add(input logic we, input logic [15:0] a, input logic [7:0] d,
                     input int kind, input int gap, input string tag);
    ex_we[nex] = we; ex_addr[nex] = a; ex_data[nex] = d;
    ex_kind[nex] = kind; ex_gap[nex] = gap; ex_tag[nex] = tag;
    nex++;
  endtask

  task automatic run_one(input int ms, input int lr, input int zt, input int p);
    logic [15:0] m, u1, u2, em, ed, am, ad;
    int g, en, ex, t;
    case (p)
      0: begin idb = '{8'hBF, 8'hB5, 8'h00, 8'h00}; arb = '{8'hFF, 8'hFF, 8'hFF, 8'hFF}; end
      1: begin idb = '{8'h7F, 8'h13, 8'h9D, 8'h00}; arb = '{8'h00, 8'h00, 8'h00, 8'h00}; end
      2: begin idb = '{8'h01, 8'h7F, 8'h00, 8'h42}; arb = '{8'hFF, 8'hFF, 8'hFF, 8'hFF}; end
      3: begin idb = '{8'h7F, 8'h7F, 8'h1C, 8'h2A}; arb = '{8'h7F, 8'h10, 8'h1D, 8'hFF}; end
      4: begin idb = '{8'h03, 8'hE3, 8'h00, 8'h00}; arb = '{8'hFF, 8'hFF, 8'hFF, 8'hFF}; end
      default: begin idb = '{8'h20, 8'hE3, 8'h00, 8'h00}; arb = '{8'h20, 8'hE3, 8'h00, 8'h00}; end
    endcase
    em = ext(idb[0], idb[2]); ed = ext(idb[1], idb[3]);
    am = ext(arb[0], arb[2]); ad = ext(arb[1], arb[3]);
    m = mask_of(ms); u1 = 16'h5555 & m; u2 = 16'h2AAA & m;
    g = zt ? 0 : GAP; en = zt ? 0 : ENTER; ex = zt ? 0 : EXIT;

    nex = 0;
    if (lr != 0) begin
      add(1, u1, 8'hAA, K_MIN, en, "R1,R2");
      add(1, u2, 8'h55, K_EXACT, g, "R1,R2");
      add(1, u1, 8'hF0, K_EXACT, g, "R2");
    end else add(1, u1, 8'hF0, K_MIN, en, "R1,R2");
    add(1, u1, 8'hAA, K_MIN, ex, "R1,R3,R4");
    add(1, u2, 8'h55, K_EXACT, g, "R1,R3,R4");
    add(1, u1, 8'h90, K_EXACT, g, "R3,R4");
    add(0, 16'h0000, 8'h00, K_MIN, en, "R5,R4");
    add(0, 16'h0001, 8'h00, K_NONE, 0, "R5");
    if (idb[0] == 8'h7F) add(0, 16'h0100, 8'h00, K_NONE, 0, "R5");
    if (idb[1] == 8'h7F) add(0, 16'h0101, 8'h00, K_NONE, 0, "R5");
    if (lr != 0) begin
      add(1, u1, 8'hAA, K_NONE, 0, "R6");
      add(1, u2, 8'h55, K_EXACT, g, "R6");
      add(1, u1, 8'hF0, K_EXACT, g, "R6");
    end else add(1, u1, 8'hF0, K_NONE, 0, "R6");
    add(0, 16'h0000, 8'h00, K_MIN, ex, "R6,R4");
    add(0, 16'h0001, 8'h00, K_NONE, 0, "R6");
    if (arb[0] == 8'h7F) add(0, 16'h0100, 8'h00, K_NONE, 0, "R6");
    if (arb[1] == 8'h7F) add(0, 16'h0101, 8'h00, K_NONE, 0, "R6");

    msel = 2'(ms); long_rst = (lr != 0); zero_t = (zt != 0);
    exp_mfr = em; exp_dev = (p == 5) ? (ed ^ 16'h0001) : ed;
    mdl_mask = m; idmode = 0; ulk = 0;
    ntr = 0; done_cnt = 0; hold_err = 0; lat_cnt = 0; holding = 0;

    @(negedge clk); start = 1'b1; low_cnt = 0;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (p == 0) begin
      // start while busy: must not restart or add transfers
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);

    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(busy == 1'b0, "R10", "busy after done", busy, 0);
    chk(ntr == nex, "R6", "transfer count", ntr, nex);
    for (int i = 0; i < nex && i < ntr; i++) begin
      chk(tr_we[i] == ex_we[i] && tr_addr[i] == ex_addr[i] && tr_data[i] == ex_data[i],
          ex_tag[i], $sformatf("transfer %0d {we,addr,data}", i),
          {tr_we[i], tr_addr[i], tr_data[i]}, {ex_we[i], ex_addr[i], ex_data[i]});
      if (ex_kind[i] == K_EXACT)
        chk(tr_gap[i] == ex_gap[i], "R4", $sformatf("exact gap before %0d", i), tr_gap[i], ex_gap[i]);
      else if (ex_kind[i] == K_MIN)
        chk(tr_gap[i] >= ex_gap[i], "R4", $sformatf("min gap before %0d", i), tr_gap[i], ex_gap[i]);
    end
    chk(hold_err == 0, "R11", "address held until ack", hold_err, 0);
    chk(mfr_id == em, "R5", "manufacturer code", mfr_id, em);
    chk(dev_id == ed, "R5", "device code", dev_id, ed);
    chk(par_err == ~^em[7:0], "R8", "parity flag", par_err, ~^em[7:0]);
    chk(mfr_arr == (am == em), "R7", "mfr array flag", mfr_arr, am == em);
    chk(dev_arr == (ad == ed), "R7", "dev array flag", dev_arr, ad == ed);
    chk(match == (p != 5), "R9", "match", match, p != 5);
  endtask

  initial begin
    start = 0; msel = 0; long_rst = 0; zero_t = 0; exp_mfr = 0; exp_dev = 0;
    idmode = 0; ulk = 0; mdl_mask = 16'hFFFF; ntr = 0; low_cnt = 0; lat_cnt = 0;
    done_cnt = 0; hold_err = 0; run_idx = 0; holding = 0;
    repeat (3) @(negedge clk);
    chk(bus_req == 0 && busy == 0 && done == 0, "R12", "idle in reset", {bus_req, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(match == 0 && mfr_id == 0 && dev_id == 0 && par_err == 0, "R12", "outputs after reset",
        {match, par_err, mfr_id, dev_id}, 0);
    chk(bus_req == 0 && busy == 0, "R12", "no request after reset", {bus_req, busy}, 0);
    for (int ms = 0; ms < 4; ms++)
      for (int lr = 0; lr < 2; lr++)
        for (int zt = 0; zt < 2; zt++)
          for (int p = 0; p < 6; p++) begin
            run_one(ms, lr, zt, p);
            run_idx++;
          end
    finish_run();
  end

endmodule